// File: doc/BRIEF.md
# Dual-Lane Simultaneous-Sampling Conversion Sequencer

This block is the digital control core of a two-converter, four-input sampling ADC. It watches an active-low start request and a one-bit input-pair select, and it runs from the conversion clock. When the start request falls, the sample-and-hold control goes to hold at once, with no clock edge needed. The busy flag rises at the same moment. On the next rising clock edge the block captures the pair select and begins a fixed conversion frame. During this frame both converter lanes resolve their bits side by side.

Each lane replaces the analog successive-approximation loop with a behavioural stand-in. In the default variant, a digital SAR register presents a trial word each cycle. It then keeps or drops the bit under test, based on an external comparator decision, which the bench models. With `SAR_EN = 0` the lane instead captures a direct result input at the end of the frame. At the end of the frame, both results and the latched pair index are presented together with a one-cycle valid strobe.

Top module: `adc_seq_core`

## Requirements
- R1: `hold_o` rises as soon as `conv_n_i` falls, with no clock edge, when the block is idle and armed. It stays high through the conversion and drops in the same cycle as `busy_o`.
- R2: `busy_o` rises as soon as `conv_n_i` falls, with no clock edge, when the block is idle and armed.
- R3: A conversion starts on the first rising edge that samples `conv_n_i` low. `busy_o` falls right after the 16th rising edge following that start edge, so one frame lasts `CYCLES` = 16 clock cycles. A new start needs `conv_n_i` to be sampled high at some edge after the previous start.
- R4: `addr_i` is captured on the start edge. Value 0 selects input 0 of both converters and value 1 selects input 1 of both. `res_ch_o` reports the captured value. Changes to `addr_i` after the start edge have no effect on `res_ch_o`.
- R5: The SAR lane resolves one bit per cycle, MSB first, in frame cycles 2 to 13. In each of these cycles `trial_*_o` equals the bits already kept, plus the bit under test. A comparator input of 1 keeps that bit. The SAR code is offset binary.
- R6: Results are 12-bit two's complement, formed by inverting the MSB of the offset code. The code points are: 0x7FF is plus full scale, 0x000 is midscale, 0xFFF is one LSB below midscale, and 0x800 is minus full scale.
- R7: Both lanes convert in the same frame from the same clock. Both results appear on the same strobe.
- R8: `res_valid_o` is high for exactly one cycle, in the cycle right after `busy_o` falls. `res_a_o`, `res_b_o` and `res_ch_o` are valid with the strobe and hold until the next strobe.
- R9: A falling edge of `conv_n_i` seen while a conversion is active is ignored. The frame length does not change, and no new conversion starts after the frame, even if `conv_n_i` stays low. `err_cnt_o` increases by one, modulo 2^`ERR_W`.
- R10: After reset, `busy_o`, `hold_o`, `res_valid_o` and `err_cnt_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Conversion clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| conv_n_i | input | 1 | Active-low conversion start request |
| addr_i | input | 1 | Input-pair select, captured on the start edge |
| cmp_a_i | input | 1 | Comparator decision for lane A (1 = input at or above trial) |
| cmp_b_i | input | 1 | Comparator decision for lane B |
| direct_a_i | input | W | Direct result for lane A (used when SAR_EN = 0) |
| direct_b_i | input | W | Direct result for lane B (used when SAR_EN = 0) |
| hold_o | output | 1 | Sample-and-hold control for both lanes, 1 = hold |
| busy_o | output | 1 | Conversion in progress |
| trial_a_o | output | W | Lane A SAR trial word (offset binary) |
| trial_b_o | output | W | Lane B SAR trial word (offset binary) |
| res_valid_o | output | 1 | One-cycle result strobe |
| res_a_o | output | W | Lane A result, two's complement |
| res_b_o | output | W | Lane B result, two's complement |
| res_ch_o | output | 1 | Input-pair index of the delivered results |
| err_cnt_o | output | ERR_W | Count of start requests ignored while busy |

## Verification
A frame counter that is off by one shows up within the first conversion: `busy_o` falls one edge early or late, and the strobe moves with it. A wrong bit index or MSB-order slip in a SAR lane corrupts the result on the very first strobe. This holds for any input whose lower bits are not all equal. Lost arming state shows up in two ways after an ignored request. Either a spurious second frame starts while the request is still low, or a real request never starts one. The bench drives such requests and checks `busy_o` a few cycles after the frame ends.

// File: rtl/adc_seq_pkg.sv
`timescale 1ns/1ps
package adc_seq_pkg;
  typedef enum logic [1:0] {
    PH_START   = 2'd0,
    PH_RESOLVE = 2'd1,
    PH_TAIL    = 2'd2,
    PH_WRITE   = 2'd3
  } phase_e;
endpackage

// File: rtl/adc_seq_ctrl.sv
`timescale 1ns/1ps
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int W      = 12,
  parameter int CYCLES = 16,
  parameter int ERR_W  = 8,
  localparam int CW    = $clog2(CYCLES),
  localparam int BW    = $clog2(W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             conv_n_i,
  input  logic             addr_i,
  output logic             start_o,
  output logic             busy_o,
  output phase_e           phase_o,
  output logic [BW-1:0]    bit_idx_o,
  output logic             ch_o,
  output logic [ERR_W-1:0] err_cnt_o
);
  logic          active_q, armed_q, conv_q, ch_q;
  logic [CW-1:0] cnt_q;
  logic [ERR_W-1:0] err_q;
  logic          err_edge, last;
  int            bit_pos;

  assign start_o  = ~active_q & ~conv_n_i & armed_q;
  assign err_edge = active_q & conv_q & ~conv_n_i;
  assign last     = active_q & (cnt_q == CW'(CYCLES - 1));
  // asynchronous rise: request low while armed raises busy before any edge
  assign busy_o   = active_q | (~conv_n_i & armed_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      armed_q  <= 1'b0;
      conv_q   <= 1'b1;
      ch_q     <= 1'b0;
      cnt_q    <= '0;
      err_q    <= '0;
    end else begin
      conv_q <= conv_n_i;
      if (start_o) begin
        active_q <= 1'b1;
        cnt_q    <= '0;
        ch_q     <= addr_i;
      end else if (last) begin
        active_q <= 1'b0;
      end else if (active_q) begin
        cnt_q <= cnt_q + 1'b1;
      end
      if (start_o || err_edge) armed_q <= 1'b0;
      else if (conv_n_i)       armed_q <= 1'b1;
      if (err_edge) err_q <= err_q + 1'b1;
    end
  end

  always_comb begin
    if (!active_q || cnt_q == '0)        phase_o = PH_START;
    else if (int'(cnt_q) <= W)           phase_o = PH_RESOLVE;
    else if (last)                       phase_o = PH_WRITE;
    else                                 phase_o = PH_TAIL;
    bit_pos   = W - int'(cnt_q);
    bit_idx_o = bit_pos[BW-1:0];
  end

  assign ch_o      = ch_q;
  assign err_cnt_o = err_q;
endmodule

// File: rtl/adc_sar_lane.sv
`timescale 1ns/1ps
module adc_sar_lane
  import adc_seq_pkg::*;
#(
  parameter int W      = 12,
  parameter bit SAR_EN = 1'b1,
  localparam int BW    = $clog2(W)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  phase_e        phase_i,
  input  logic [BW-1:0] bit_idx_i,
  input  logic          cmp_i,
  input  logic [W-1:0]  direct_i,
  output logic [W-1:0]  trial_o,
  output logic [W-1:0]  res_o
);
  localparam logic [W-1:0] MSB = {1'b1, {(W-1){1'b0}}};
  logic [W-1:0] sar_q, res_q, probe;

  assign probe   = {{(W-1){1'b0}}, 1'b1} << bit_idx_i;
  assign trial_o = (phase_i == PH_RESOLVE) ? (sar_q | probe) : sar_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sar_q <= '0;
      res_q <= '0;
    end else begin
      if (start_i) sar_q <= '0;
      else if (phase_i == PH_RESOLVE && cmp_i) sar_q <= sar_q | probe;
      // offset binary to two's complement: flip the sign bit
      if (phase_i == PH_WRITE) res_q <= SAR_EN ? (sar_q ^ MSB) : direct_i;
    end
  end

  assign res_o = res_q;
endmodule

// File: rtl/adc_seq_core.sv
`timescale 1ns/1ps
module adc_seq_core
  import adc_seq_pkg::*;
#(
  parameter int W      = 12,
  parameter int CYCLES = 16,
  parameter int ERR_W  = 8,
  parameter bit SAR_EN = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             conv_n_i,
  input  logic             addr_i,
  input  logic             cmp_a_i,
  input  logic             cmp_b_i,
  input  logic [W-1:0]     direct_a_i,
  input  logic [W-1:0]     direct_b_i,
  output logic             hold_o,
  output logic             busy_o,
  output logic [W-1:0]     trial_a_o,
  output logic [W-1:0]     trial_b_o,
  output logic             res_valid_o,
  output logic [W-1:0]     res_a_o,
  output logic [W-1:0]     res_b_o,
  output logic             res_ch_o,
  output logic [ERR_W-1:0] err_cnt_o
);
  localparam int BW    = $clog2(W);
  localparam int LANES = 2;

  logic          start, busy, ch;
  phase_e        phase;
  logic [BW-1:0] bit_idx;
  logic          valid_q, ch_q;
  logic [LANES-1:0]        cmp;
  logic [LANES-1:0][W-1:0] direct, trial, res;

  adc_seq_ctrl #(.W(W), .CYCLES(CYCLES), .ERR_W(ERR_W)) u_ctrl (
    .clk_i, .rst_ni, .conv_n_i, .addr_i,
    .start_o(start), .busy_o(busy), .phase_o(phase),
    .bit_idx_o(bit_idx), .ch_o(ch), .err_cnt_o
  );

  assign cmp    = {cmp_b_i, cmp_a_i};
  assign direct = {direct_b_i, direct_a_i};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    adc_sar_lane #(.W(W), .SAR_EN(SAR_EN)) u_lane (
      .clk_i, .rst_ni, .start_i(start), .phase_i(phase),
      .bit_idx_i(bit_idx), .cmp_i(cmp[g]), .direct_i(direct[g]),
      .trial_o(trial[g]), .res_o(res[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      ch_q    <= 1'b0;
    end else begin
      valid_q <= (phase == PH_WRITE);
      if (phase == PH_WRITE) ch_q <= ch;
    end
  end

  assign hold_o      = busy;
  assign busy_o      = busy;
  assign trial_a_o   = trial[0];
  assign trial_b_o   = trial[1];
  assign res_a_o     = res[0];
  assign res_b_o     = res[1];
  assign res_valid_o = valid_q;
  assign res_ch_o    = ch_q;
endmodule

// File: rtl/adc_seq_chk.sv
`timescale 1ns/1ps
module adc_seq_chk #(
  parameter int CYCLES = 16,
  parameter int ERR_W  = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             busy_o,
  input logic             res_valid_o,
  input logic             res_ch_o,
  input logic [ERR_W-1:0] err_cnt_o
);
  localparam int BCW = $clog2(CYCLES) + 2;
  logic [BCW-1:0] bcnt;

  // busy samples since last strobe: start edge plus frame edges
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          bcnt <= '0;
    else if (res_valid_o) bcnt <= busy_o ? BCW'(1) : '0;
    else if (busy_o)      bcnt <= bcnt + 1'b1;
    else                  bcnt <= '0;
  end

  a_r3_frame_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(res_valid_o) |-> bcnt == BCW'(CYCLES + 1));

  a_r8_single_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |=> !res_valid_o);

  a_r8_strobe_after_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> res_valid_o);

  a_r4_ch_only_on_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(res_ch_o) |-> res_valid_o);

  a_r9_err_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(err_cnt_o) |-> ($past(busy_o) && err_cnt_o == $past(err_cnt_o) + 1'b1));
endmodule

bind adc_seq_core adc_seq_chk #(.CYCLES(CYCLES), .ERR_W(ERR_W)) u_chk (
  .clk_i, .rst_ni, .busy_o, .res_valid_o, .res_ch_o, .err_cnt_o
);

// File: tb/adc_seq_core_bench.sv
`timescale 1ns/1ps
module adc_seq_core_bench;
  logic        clk = 1'b0, rst_n = 1'b0, conv_n = 1'b1, addr = 1'b0;
  logic [11:0] va = '0, vb = '0;
  logic        cmp_a, cmp_b, hold, busy, res_valid, res_ch;
  logic [11:0] trial_a, trial_b, res_a, res_b;
  logic [7:0]  err_cnt;
  int checks = 0, fails = 0;
  int exp_err = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  // comparator model: offset-binary input at or above trial word
  assign cmp_a = ((va ^ 12'h800) >= trial_a);
  assign cmp_b = ((vb ^ 12'h800) >= trial_b);

  adc_seq_core u_adc_seq_core (
    .clk_i(clk), .rst_ni(rst_n), .conv_n_i(conv_n), .addr_i(addr),
    .cmp_a_i(cmp_a), .cmp_b_i(cmp_b), .direct_a_i(12'h000), .direct_b_i(12'h000),
    .hold_o(hold), .busy_o(busy), .trial_a_o(trial_a), .trial_b_o(trial_b),
    .res_valid_o(res_valid), .res_a_o(res_a), .res_b_o(res_b),
    .res_ch_o(res_ch), .err_cnt_o(err_cnt)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_conv(input logic [11:0] a, input logic [11:0] b,
                         input logic ch, input bit inject);
    va = a; vb = b;
    @(negedge clk); addr = ch;
    @(posedge clk); #2 conv_n = 1'b0; #1;
    chk(busy == 1'b1, "R2 busy async rise", busy, 1);
    chk(hold == 1'b1, "R1 hold async rise", hold, 1);
    @(posedge clk); #1 addr = ~ch;              // start edge passed
    for (int k = 1; k <= 16; k++) begin
      @(posedge clk); #1;
      if (k == 1) conv_n = 1'b1;
      if (inject && k == 3) conv_n = 1'b0;      // ignored request
      if (k == 15) begin
        chk(busy == 1'b1, "R3 busy through frame", busy, 1);
        chk(res_valid == 1'b0, "R8 no early strobe", res_valid, 0);
      end
    end
    if (inject) exp_err = (exp_err + 1) % 256;
    chk(busy == 1'b0, "R3 busy falls after 16 edges", busy, 0);
    chk(hold == 1'b0, "R1 hold released", hold, 0);
    chk(res_valid == 1'b1, "R8 strobe", res_valid, 1);
    chk(res_a == a, "R5 R6 lane A result", res_a, a);
    chk(res_b == b, "R7 lane B result", res_b, b);
    chk(res_ch == ch, "R4 latched channel", res_ch, ch);
    chk(err_cnt == 8'(exp_err), "R9 error count", err_cnt, exp_err);
    @(posedge clk); #1;
    chk(res_valid == 1'b0, "R8 strobe one cycle", res_valid, 0);
    chk(res_a == a && res_b == b, "R8 results held", res_a, a);
    if (inject) begin
      repeat (3) @(posedge clk);
      #1;
      chk(busy == 1'b0, "R9 no restart from ignored request", busy, 0);
      chk(res_valid == 1'b0, "R9 no extra strobe", res_valid, 0);
      conv_n = 1'b1;
      @(posedge clk); #1;
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1207));
    #1;
    chk(busy == 1'b0, "R10 busy in reset", busy, 0);
    chk(hold == 1'b0, "R10 hold in reset", hold, 0);
    chk(res_valid == 1'b0, "R10 valid in reset", res_valid, 0);
    chk(err_cnt == 8'd0, "R10 err in reset", err_cnt, 0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (2) @(posedge clk);
    // R6 code points
    do_conv(12'h7FF, 12'h800, 1'b0, 1'b0);
    do_conv(12'h000, 12'hFFF, 1'b1, 1'b0);
    do_conv(12'h800, 12'h7FF, 1'b1, 1'b0);
    do_conv(12'h555, 12'hAAA, 1'b0, 1'b1);
    do_conv(12'h001, 12'hFFE, 1'b1, 1'b1);
    for (int i = 0; i < 40; i++) begin
      logic [11:0] ra, rb;
      ra = 12'($urandom);
      rb = 12'($urandom);
      do_conv(ra, rb, 1'($urandom), (i % 5) == 3);
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, fails);
    $finish;
  end
endmodule